// File: doc/BRIEF.md
# Circular Return-Address Stack

This block keeps return addresses for procedure calls in a small ring of entries. Each entry pairs a PC word with a status word. Three pieces of state describe the ring: an index to the oldest entry, an index to the newest entry, and an entry count. A call stores its PC and status one slot past the newest entry. A return removes the newest entry, and that entry's PC and status are always on view so that the return can use them.

Supervisor software reaches the ring through a port selected by a two-bit register number:

- The PC of the oldest entry can be read, which removes it, or written, which inserts a new oldest entry. This lets the ring be saved to memory and loaded back from it.
- The other three selections read or overwrite a word in place.

A port access takes a fixed number of extra cycles beyond a plain register access. Protection and capacity errors come back as one-cycle flags with the completion pulse, and they leave the stack untouched.

Top module: `ctlstk_top`

## Requirements
- R1: After reset the count is 0. busy_o, acc_done_o, all error flags and full_warn_o are low.
- R2: A call with count below LIMIT writes call_pc_i and call_st_i into the slot after the newest entry and increments the count. ret_pc_o and ret_st_o always show the newest entry.
- R3: A return with count above 0 drops the newest entry and decrements the count. When call_i and ret_i are both high in one cycle, only the return takes effect.
- R4: A return with count 0 pulses ret_err_o for one cycle and changes nothing.
- R5: A call with count equal to LIMIT pulses push_ovf_o and changes nothing. full_warn_o is high exactly when count equals LIMIT.
- R6: acc_done_o rises ACC_EXTRA+1 clock edges after the edge that accepts acc_valid_i, and busy_o is high in between. While busy_o is high, call_i, ret_i and acc_valid_i are ignored.
- R7: Reading selection 0 (oldest PC) returns that PC. The oldest index then moves forward one slot, modulo DEPTH, and the count drops by one.
- R8: Writing selection 0 moves the oldest index back one slot, stores the PC there and increments the count. If the count already equals LIMIT, it instead pulses push_ovf_o and changes nothing.
- R9: Selection 1 (oldest status), selection 2 (newest PC) and selection 3 (newest status) read or overwrite that word in place. A status read returns the status word zero-extended in acc_rdata_o. These selections never change the count or the indices.
- R10: With acc_user_i high, a read of selection 0 or any write pulses mode_fault_o and changes nothing. A user-mode read of selections 1 to 3 completes normally.
- R11: With count 0, any port access other than a write of selection 0 pulses port_err_o and changes nothing.
- R12: Indices wrap modulo DEPTH, so the ring works through any number of calls, returns and oldest-entry removals.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| call_i | input | 1 | Push a return entry |
| call_pc_i | input | PC_W | PC to push |
| call_st_i | input | ST_W | Status to push |
| ret_i | input | 1 | Pop the newest entry |
| ret_pc_o | output | PC_W | PC of the newest entry |
| ret_st_o | output | ST_W | Status of the newest entry |
| ret_err_o | output | 1 | Return attempted on an empty ring |
| acc_valid_i | input | 1 | Start a port access |
| acc_sel_i | input | 2 | 0 oldest PC, 1 oldest status, 2 newest PC, 3 newest status |
| acc_wr_i | input | 1 | 1 write, 0 read |
| acc_wdata_i | input | PC_W | Write data (status writes use the low ST_W bits) |
| acc_user_i | input | 1 | Access issued in user mode |
| busy_o | output | 1 | Port access in progress |
| acc_done_o | output | 1 | Port access completed (one cycle) |
| acc_rdata_o | output | PC_W | Read result, valid with acc_done_o |
| mode_fault_o | output | 1 | Privilege violation, valid with acc_done_o |
| port_err_o | output | 1 | Access on an empty ring, valid with acc_done_o |
| push_ovf_o | output | 1 | Push refused because the ring is at LIMIT |
| full_warn_o | output | 1 | Count equals LIMIT |
| count_o | output | CW | Number of entries held |

## Verification
A reference ring in the bench is driven by the same calls, returns and port accesses as the design. A queue of predicted completions is checked as each acc_done_o arrives.

The stimulus falls into four patterns, and each one isolates a different fault:

- Filling the ring to LIMIT and then draining it by returns shows whether the capacity compare is correct and whether returns come back in the right order.
- Alternating a call with a removal of the oldest entry moves both indices around the ring many times without filling it. This exposes a wrong wrap.
- In-place overwrites read back later show whether a port touched the wrong slot or altered the count.
- User-mode, empty-ring and busy-time accesses must leave the reference state intact. They separate a missing protection check from a missing empty check.

// File: rtl/ctlstk_pkg.sv
package ctlstk_pkg;

   typedef enum logic [1:0] {
      PSEL_OLD_PC = 2'd0,
      PSEL_OLD_ST = 2'd1,
      PSEL_NEW_PC = 2'd2,
      PSEL_NEW_ST = 2'd3
   } psel_e;

   typedef enum logic [2:0] {
      PTR_HOLD       = 3'd0,
      PTR_GROW_NEW   = 3'd1,
      PTR_SHRINK_NEW = 3'd2,
      PTR_GROW_OLD   = 3'd3,
      PTR_SHRINK_OLD = 3'd4
   } ptr_op_e;

endpackage

// File: rtl/ctlstk_store.sv
module ctlstk_store #(
   parameter int DEPTH          = 8,
   parameter int IW             = 3,
   parameter int PC_W           = 32,
   parameter int ST_W           = 16,
   parameter bit CLEAR_ON_RESET = 1'b1
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we_pc_i,
   input  logic            we_st_i,
   input  logic [IW-1:0]   waddr_i,
   input  logic [PC_W-1:0] wpc_i,
   input  logic [ST_W-1:0] wst_i,
   input  logic [IW-1:0]   raddr_a_i,
   input  logic [IW-1:0]   raddr_b_i,
   output logic [PC_W-1:0] rd_pc_a_o,
   output logic [ST_W-1:0] rd_st_a_o,
   output logic [PC_W-1:0] rd_pc_b_o,
   output logic [ST_W-1:0] rd_st_b_o
);

   logic [PC_W-1:0] pc_mem [DEPTH];
   logic [ST_W-1:0] st_mem [DEPTH];

   generate
      if (CLEAR_ON_RESET) begin : g_clr
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               for (int i = 0; i < DEPTH; i++) begin
                  pc_mem[i] <= '0;
                  st_mem[i] <= '0;
               end
            end else begin
               if (we_pc_i) pc_mem[waddr_i] <= wpc_i;
               if (we_st_i) st_mem[waddr_i] <= wst_i;
            end
         end
      end else begin : g_noclr
         always_ff @(posedge clk) begin
            if (we_pc_i) pc_mem[waddr_i] <= wpc_i;
            if (we_st_i) st_mem[waddr_i] <= wst_i;
         end
      end
   endgenerate

   assign rd_pc_a_o = pc_mem[raddr_a_i];
   assign rd_st_a_o = st_mem[raddr_a_i];
   assign rd_pc_b_o = pc_mem[raddr_b_i];
   assign rd_st_b_o = st_mem[raddr_b_i];

endmodule

// File: rtl/ctlstk_ptrs.sv
module ctlstk_ptrs
   import ctlstk_pkg::*;
#(
   parameter int DEPTH = 8,
   parameter int LIMIT = 8,
   parameter int IW    = 3,
   parameter int CW    = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  ptr_op_e       op_i,
   output logic [IW-1:0] old_o,
   output logic [IW-1:0] new_o,
   output logic [IW-1:0] old_dn_o,
   output logic [IW-1:0] new_up_o,
   output logic [CW-1:0] cnt_o
);

   logic [IW-1:0] old_q, new_q;
   logic [CW-1:0] cnt_q;

   function automatic logic [IW-1:0] step_up(input logic [IW-1:0] i);
      return (i == IW'(DEPTH-1)) ? '0 : i + 1'b1;
   endfunction

   function automatic logic [IW-1:0] step_dn(input logic [IW-1:0] i);
      return (i == '0) ? IW'(DEPTH-1) : i - 1'b1;
   endfunction

   assign old_dn_o = step_dn(old_q);
   assign new_up_o = step_up(new_q);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         old_q <= '0;
         new_q <= IW'(DEPTH-1);
         cnt_q <= '0;
      end else begin
         unique case (op_i)
            PTR_GROW_NEW: begin
               new_q <= step_up(new_q);
               cnt_q <= cnt_q + 1'b1;
            end
            PTR_SHRINK_NEW: begin
               new_q <= step_dn(new_q);
               cnt_q <= cnt_q - 1'b1;
            end
            PTR_GROW_OLD: begin
               old_q <= step_dn(old_q);
               cnt_q <= cnt_q + 1'b1;
            end
            PTR_SHRINK_OLD: begin
               old_q <= step_up(old_q);
               cnt_q <= cnt_q - 1'b1;
            end
            default: ;
         endcase
      end
   end

   assign old_o = old_q;
   assign new_o = new_q;
   assign cnt_o = cnt_q;

   // R12
   ptr_ring_chk: assert property (@(posedge clk) disable iff (!rst_n)
      int'(new_q) == (int'(old_q) + int'(cnt_q) + DEPTH - 1) % DEPTH);

   // R8
   cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CW'(LIMIT));

endmodule

// File: rtl/ctlstk_port_seq.sv
module ctlstk_port_seq #(
   parameter int ACC_EXTRA = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start_i,
   output logic busy_o,
   output logic commit_o
);

   localparam int CTW = (ACC_EXTRA < 1) ? 1 : $clog2(ACC_EXTRA + 1);

   logic [CTW-1:0] cnt_q;
   logic           pend_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         pend_q <= 1'b0;
         cnt_q  <= '0;
      end else if (!pend_q) begin
         if (start_i) begin
            pend_q <= 1'b1;
            cnt_q  <= CTW'(ACC_EXTRA);
         end
      end else if (cnt_q == '0) begin
         pend_q <= 1'b0;
      end else begin
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign busy_o   = pend_q;
   assign commit_o = pend_q && (cnt_q == '0);

endmodule

// File: rtl/ctlstk_top.sv
module ctlstk_top
   import ctlstk_pkg::*;
#(
   parameter int DEPTH          = 8,
   parameter int LIMIT          = 8,
   parameter int PC_W           = 32,
   parameter int ST_W           = 16,
   parameter int ACC_EXTRA      = 4,
   parameter bit CLEAR_ON_RESET = 1'b1,
   localparam int IW            = $clog2(DEPTH),
   localparam int CW            = $clog2(DEPTH + 1)
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            call_i,
   input  logic [PC_W-1:0] call_pc_i,
   input  logic [ST_W-1:0] call_st_i,
   input  logic            ret_i,
   output logic [PC_W-1:0] ret_pc_o,
   output logic [ST_W-1:0] ret_st_o,
   output logic            ret_err_o,
   input  logic            acc_valid_i,
   input  logic [1:0]      acc_sel_i,
   input  logic            acc_wr_i,
   input  logic [PC_W-1:0] acc_wdata_i,
   input  logic            acc_user_i,
   output logic            busy_o,
   output logic            acc_done_o,
   output logic [PC_W-1:0] acc_rdata_o,
   output logic            mode_fault_o,
   output logic            port_err_o,
   output logic            push_ovf_o,
   output logic            full_warn_o,
   output logic [CW-1:0]   count_o
);

   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("ctlstk_top: DEPTH must be at least 2");
      end
      if (LIMIT < 1 || LIMIT > DEPTH) begin : g_bad_limit
         $error("ctlstk_top: LIMIT must lie in 1..DEPTH");
      end
      if (ST_W > PC_W) begin : g_bad_st
         $error("ctlstk_top: ST_W must not exceed PC_W");
      end
      if (ACC_EXTRA < 0) begin : g_bad_extra
         $error("ctlstk_top: ACC_EXTRA must be non-negative");
      end
   endgenerate

   // pointer and count state
   ptr_op_e       ptr_op;
   logic [IW-1:0] old_idx, new_idx, old_dn, new_up;
   logic [CW-1:0] cnt;

   ctlstk_ptrs #(.DEPTH(DEPTH), .LIMIT(LIMIT), .IW(IW), .CW(CW)) u_ptrs (
      .clk      (clk),
      .rst_n    (rst_n),
      .op_i     (ptr_op),
      .old_o    (old_idx),
      .new_o    (new_idx),
      .old_dn_o (old_dn),
      .new_up_o (new_up),
      .cnt_o    (cnt)
   );

   // entry storage
   logic            we_pc, we_st;
   logic [IW-1:0]   waddr;
   logic [PC_W-1:0] wpc;
   logic [ST_W-1:0] wst;
   logic [PC_W-1:0] old_pc, new_pc;
   logic [ST_W-1:0] old_st, new_st;

   ctlstk_store #(
      .DEPTH(DEPTH), .IW(IW), .PC_W(PC_W), .ST_W(ST_W),
      .CLEAR_ON_RESET(CLEAR_ON_RESET)
   ) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .we_pc_i   (we_pc),
      .we_st_i   (we_st),
      .waddr_i   (waddr),
      .wpc_i     (wpc),
      .wst_i     (wst),
      .raddr_a_i (old_idx),
      .raddr_b_i (new_idx),
      .rd_pc_a_o (old_pc),
      .rd_st_a_o (old_st),
      .rd_pc_b_o (new_pc),
      .rd_st_b_o (new_st)
   );

   // port access sequencer
   logic busy, commit, start;

   assign start = acc_valid_i && !busy;

   ctlstk_port_seq #(.ACC_EXTRA(ACC_EXTRA)) u_seq (
      .clk      (clk),
      .rst_n    (rst_n),
      .start_i  (start),
      .busy_o   (busy),
      .commit_o (commit)
   );

   // captured request
   psel_e           req_sel;
   logic            req_wr, req_user;
   logic [PC_W-1:0] req_data;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         req_sel  <= PSEL_OLD_PC;
         req_wr   <= 1'b0;
         req_user <= 1'b0;
         req_data <= '0;
      end else if (start) begin
         req_sel  <= psel_e'(acc_sel_i);
         req_wr   <= acc_wr_i;
         req_user <= acc_user_i;
         req_data <= acc_wdata_i;
      end
   end

   // decision logic
   logic            fault_n, perr_n, ovf_n, rerr_n;
   logic [PC_W-1:0] rdata_n;
   logic            is_opc, priv;

   always_comb begin
      ptr_op  = PTR_HOLD;
      we_pc   = 1'b0;
      we_st   = 1'b0;
      waddr   = new_up;
      wpc     = call_pc_i;
      wst     = call_st_i;
      fault_n = 1'b0;
      perr_n  = 1'b0;
      ovf_n   = 1'b0;
      rerr_n  = 1'b0;
      rdata_n = '0;
      is_opc  = (req_sel == PSEL_OLD_PC);
      priv    = req_wr || is_opc;
      if (commit) begin
         if (req_user && priv) begin
            fault_n = 1'b1;
         end else if (!(req_wr && is_opc) && cnt == '0) begin
            perr_n = 1'b1;
         end else if (req_wr && is_opc && cnt >= CW'(LIMIT)) begin
            ovf_n = 1'b1;
         end else begin
            wpc = req_data;
            wst = req_data[ST_W-1:0];
            unique case (req_sel)
               PSEL_OLD_PC: begin
                  if (req_wr) begin
                     ptr_op = PTR_GROW_OLD;
                     we_pc  = 1'b1;
                     waddr  = old_dn;
                  end else begin
                     ptr_op  = PTR_SHRINK_OLD;
                     rdata_n = old_pc;
                  end
               end
               PSEL_OLD_ST: begin
                  waddr = old_idx;
                  if (req_wr) we_st = 1'b1;
                  else        rdata_n = PC_W'(old_st);
               end
               PSEL_NEW_PC: begin
                  waddr = new_idx;
                  if (req_wr) we_pc = 1'b1;
                  else        rdata_n = new_pc;
               end
               default: begin
                  waddr = new_idx;
                  if (req_wr) we_st = 1'b1;
                  else        rdata_n = PC_W'(new_st);
               end
            endcase
         end
      end else if (!busy) begin
         if (ret_i) begin
            if (cnt == '0) rerr_n = 1'b1;
            else           ptr_op = PTR_SHRINK_NEW;
         end else if (call_i) begin
            if (cnt >= CW'(LIMIT)) begin
               ovf_n = 1'b1;
            end else begin
               ptr_op = PTR_GROW_NEW;
               we_pc  = 1'b1;
               we_st  = 1'b1;
            end
         end
      end
   end

   // registered responses
   logic            done_q, fault_q, perr_q, ovf_q, rerr_q;
   logic [PC_W-1:0] rdata_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         done_q  <= 1'b0;
         fault_q <= 1'b0;
         perr_q  <= 1'b0;
         ovf_q   <= 1'b0;
         rerr_q  <= 1'b0;
         rdata_q <= '0;
      end else begin
         done_q  <= commit;
         fault_q <= fault_n;
         perr_q  <= perr_n;
         ovf_q   <= ovf_n;
         rerr_q  <= rerr_n;
         rdata_q <= rdata_n;
      end
   end

   assign ret_pc_o     = new_pc;
   assign ret_st_o     = new_st;
   assign ret_err_o    = rerr_q;
   assign busy_o       = busy;
   assign acc_done_o   = done_q;
   assign acc_rdata_o  = rdata_q;
   assign mode_fault_o = fault_q;
   assign port_err_o   = perr_q;
   assign push_ovf_o   = ovf_q;
   assign full_warn_o  = (cnt == CW'(LIMIT));
   assign count_o      = cnt;

   // R4
   ret_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ret_err_o |-> (count_o == '0));

   // R5
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      push_ovf_o |-> $stable(count_o));

   // R10
   fault_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_fault_o |-> $stable(count_o));

   // R6
   done_at_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy_o) |-> acc_done_o);

endmodule

// File: tb/test_ctlstk_top.sv
`timescale 1ns/1ps
module test_ctlstk_top;

   localparam int DEPTH = 8;
   localparam int LIM   = 8;
   localparam int EXTRA = 4;
   localparam int PCW   = 32;
   localparam int STW   = 16;
   localparam int CW    = 4;
   localparam int S_OPC = 0, S_OST = 1, S_YPC = 2, S_YST = 3;

   logic            clk = 1'b0;
   logic            rst_n;
   logic            call_i, ret_i, acc_valid_i, acc_wr_i, acc_user_i;
   logic [PCW-1:0]  call_pc_i, acc_wdata_i;
   logic [STW-1:0]  call_st_i;
   logic [1:0]      acc_sel_i;
   logic [PCW-1:0]  ret_pc_o, acc_rdata_o;
   logic [STW-1:0]  ret_st_o;
   logic            ret_err_o, busy_o, acc_done_o, mode_fault_o;
   logic            port_err_o, push_ovf_o, full_warn_o;
   logic [CW-1:0]   count_o;

   always #4 clk = ~clk;

   ctlstk_top #(
      .DEPTH(DEPTH), .LIMIT(LIM), .PC_W(PCW), .ST_W(STW),
      .ACC_EXTRA(EXTRA), .CLEAR_ON_RESET(1'b1)
   ) i_ctlstk_top (
      .clk(clk), .rst_n(rst_n),
      .call_i(call_i), .call_pc_i(call_pc_i), .call_st_i(call_st_i),
      .ret_i(ret_i), .ret_pc_o(ret_pc_o), .ret_st_o(ret_st_o),
      .ret_err_o(ret_err_o),
      .acc_valid_i(acc_valid_i), .acc_sel_i(acc_sel_i), .acc_wr_i(acc_wr_i),
      .acc_wdata_i(acc_wdata_i), .acc_user_i(acc_user_i),
      .busy_o(busy_o), .acc_done_o(acc_done_o), .acc_rdata_o(acc_rdata_o),
      .mode_fault_o(mode_fault_o), .port_err_o(port_err_o),
      .push_ovf_o(push_ovf_o), .full_warn_o(full_warn_o), .count_o(count_o)
   );

   int n_chk  = 0;
   int n_fail = 0;
   bit finished = 0;

   // reference ring
   logic [PCW-1:0] mpc [DEPTH];
   logic [STW-1:0] mst [DEPTH];
   int m_old = 0, m_new = DEPTH - 1, m_cnt = 0;

   typedef struct {
      logic [PCW-1:0] rdata;
      logic           fault, perr, ovf;
      string          tag;
   } exp_t;
   exp_t sb[$];
   exp_t cur;

   task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
      end
   endtask

   task automatic report();
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   endtask

   // monitor: compare each completion with the oldest prediction
   always @(negedge clk) begin
      if (rst_n && acc_done_o) begin
         if (sb.size() == 0) begin
            n_chk++;
            n_fail++;
            $display("FAIL R6 unexpected completion act=1 exp=0");
         end else begin
            cur = sb.pop_front();
            chk(cur.tag, {29'h0, acc_rdata_o, mode_fault_o, port_err_o, push_ovf_o},
                         {29'h0, cur.rdata, cur.fault, cur.perr, cur.ovf});
         end
      end
   end

   task automatic do_call(input logic [PCW-1:0] pc, input logic [STW-1:0] st, input string tag);
      bit eo = (m_cnt >= LIM);
      @(negedge clk);
      call_i = 1'b1; call_pc_i = pc; call_st_i = st;
      @(negedge clk);
      call_i = 1'b0;
      if (!eo) begin
         m_new = (m_new + 1) % DEPTH;
         mpc[m_new] = pc; mst[m_new] = st;
         m_cnt++;
      end
      chk({tag, " R5 ovf"}, push_ovf_o, eo);
      chk({tag, " R2 count"}, count_o, m_cnt);
      chk({tag, " R5 warn"}, full_warn_o, (m_cnt == LIM));
      if (m_cnt > 0) begin
         chk({tag, " R2 newest pc"}, ret_pc_o, mpc[m_new]);
         chk({tag, " R2 newest st"}, ret_st_o, mst[m_new]);
      end
   endtask

   task automatic do_ret(input string tag, input bit with_call = 0);
      bit ee = (m_cnt == 0);
      @(negedge clk);
      if (!ee) chk({tag, " R2 ret pc"}, ret_pc_o, mpc[m_new]);
      ret_i = 1'b1;
      if (with_call) begin
         call_i = 1'b1; call_pc_i = 32'hBAD0_BAD0; call_st_i = 16'hBAD0;
      end
      @(negedge clk);
      ret_i = 1'b0; call_i = 1'b0;
      if (!ee) begin
         m_new = (m_new + DEPTH - 1) % DEPTH;
         m_cnt--;
      end
      chk({tag, " R4 ret_err"}, ret_err_o, ee);
      chk({tag, " R3 count"}, count_o, m_cnt);
      if (m_cnt > 0) chk({tag, " R3 newest pc"}, ret_pc_o, mpc[m_new]);
   endtask

   task automatic do_acc(input int sel, input bit wr, input logic [PCW-1:0] d,
                         input bit usr, input string tag, input bit intrude = 0);
      exp_t e;
      bit   priv = wr || (sel == S_OPC);
      int   lat;
      e.rdata = '0; e.fault = 0; e.perr = 0; e.ovf = 0; e.tag = tag;
      if (usr && priv) e.fault = 1;
      else if (!(wr && sel == S_OPC) && m_cnt == 0) e.perr = 1;
      else if (wr && sel == S_OPC && m_cnt >= LIM) e.ovf = 1;
      else begin
         case (sel)
            S_OPC: if (wr) begin
                      m_old = (m_old + DEPTH - 1) % DEPTH;
                      mpc[m_old] = d;
                      m_cnt++;
                   end else begin
                      e.rdata = mpc[m_old];
                      m_old = (m_old + 1) % DEPTH;
                      m_cnt--;
                   end
            S_OST: if (wr) mst[m_old] = d[STW-1:0]; else e.rdata = {16'h0, mst[m_old]};
            S_YPC: if (wr) mpc[m_new] = d;          else e.rdata = mpc[m_new];
            default: if (wr) mst[m_new] = d[STW-1:0]; else e.rdata = {16'h0, mst[m_new]};
         endcase
      end
      sb.push_back(e);
      @(negedge clk);
      acc_valid_i = 1'b1; acc_sel_i = 2'(sel); acc_wr_i = wr;
      acc_wdata_i = d; acc_user_i = usr;
      @(negedge clk);
      acc_valid_i = 1'b0;
      lat = 1;
      chk({tag, " R6 busy"}, busy_o, 1'b1);
      if (intrude) begin
         call_i = 1'b1; call_pc_i = 32'hDEAD_0000; call_st_i = 16'hDEAD;
         acc_valid_i = 1'b1; acc_sel_i = 2'(S_OPC); acc_wr_i = 1'b1; acc_user_i = 1'b0;
         @(negedge clk);
         lat++;
         call_i = 1'b0; acc_valid_i = 1'b0;
      end
      while (busy_o) begin
         @(negedge clk);
         lat++;
      end
      // lat counts negedges from the one after the accepting edge: done edge is ACC_EXTRA+1 edges later
      chk({tag, " R6 latency"}, lat, EXTRA + 2);
      chk({tag, " count"}, count_o, m_cnt);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog act=timeout exp=done");
         report();
      end
   end

   initial begin
      for (int i = 0; i < DEPTH; i++) begin
         mpc[i] = '0; mst[i] = '0;
      end
      rst_n = 1'b0;
      call_i = 0; ret_i = 0; acc_valid_i = 0; acc_wr_i = 0; acc_user_i = 0;
      call_pc_i = '0; call_st_i = '0; acc_wdata_i = '0; acc_sel_i = '0;
      repeat (3) @(negedge clk);
      chk("R1 count", count_o, 0);
      chk("R1 busy", busy_o, 0);
      chk("R1 done", acc_done_o, 0);
      chk("R1 flags", {ret_err_o, mode_fault_o, port_err_o, push_ovf_o, full_warn_o}, 0);
      rst_n = 1'b1;

      // empty-ring errors
      do_ret("R4 empty return");
      do_acc(S_OST, 0, 0, 0, "R11 empty oldest status");
      do_acc(S_YPC, 0, 0, 0, "R11 empty newest pc");
      do_acc(S_OPC, 0, 0, 0, "R11 empty oldest pc read");

      // pushes and in-place ports
      for (int i = 0; i < 3; i++) do_call(32'h1000 + i, 16'h10 + 16'(i), "R2 call");
      do_acc(S_YPC, 0, 0, 0, "R9 read newest pc");
      do_acc(S_YST, 0, 0, 0, "R9 read newest st");
      do_acc(S_OST, 0, 0, 0, "R9 read oldest st");
      do_acc(S_YST, 1, 32'h0000_00AB, 0, "R9 write newest st");
      do_acc(S_OST, 1, 32'h0000_0055, 0, "R9 write oldest st");
      do_acc(S_YST, 0, 0, 0, "R9 readback newest st");
      do_acc(S_OST, 0, 0, 0, "R9 readback oldest st");
      do_acc(S_YPC, 1, 32'h7777_0000, 0, "R9 write newest pc");

      // user mode
      do_acc(S_YPC, 0, 0, 1, "R10 user read newest pc");
      do_acc(S_OPC, 0, 0, 1, "R10 user read oldest pc");
      do_acc(S_YST, 1, 32'h0000_0999, 1, "R10 user write newest st");
      do_acc(S_OPC, 1, 32'h0999_0000, 1, "R10 user write oldest pc");
      do_acc(S_YST, 0, 0, 0, "R10 newest st unchanged");

      // oldest-end removal and insertion
      do_acc(S_OPC, 0, 0, 0, "R7 pop oldest");
      do_acc(S_OPC, 0, 0, 0, "R7 pop next oldest");
      do_acc(S_OPC, 1, 32'h2000_0000, 0, "R8 insert oldest");
      do_acc(S_OPC, 1, 32'h2000_0004, 0, "R8 insert oldest again");
      do_acc(S_OST, 0, 0, 0, "R9 oldest st after insert");

      // fill to capacity
      while (m_cnt < LIM) do_call(32'h4000 + 32'(m_cnt), 16'h40 + 16'(m_cnt), "R5 fill");
      do_call(32'hFFFF_0000, 16'hFFFF, "R5 call at limit");
      do_acc(S_OPC, 1, 32'hFFFF_0004, 0, "R8 insert at limit");

      // drain in order
      while (m_cnt > 0) do_ret("R3 drain");
      do_ret("R4 return after drain");

      // wrap: both indices travel the ring repeatedly
      for (int i = 0; i < 20; i++) begin
         do_call(32'h3000 + i, 16'h300 + 16'(i), "R12 call");
         do_acc(S_OPC, 0, 0, 0, "R12 pop oldest after wrap");
      end
      for (int i = 0; i < 5; i++) do_call(32'h5000 + i, 16'h500 + 16'(i), "R12 refill");
      do_ret("R12 return");

      // busy-time inputs are ignored
      do_acc(S_YPC, 0, 0, 0, "R6 intruded access", 1);
      do_acc(S_YPC, 0, 0, 0, "R6 newest pc after intrusion");

      // simultaneous call and return: return wins
      do_ret("R3 ret beats call", 1);
      do_acc(S_YPC, 0, 0, 0, "R3 newest pc after both");
      while (m_cnt > 0) do_ret("R3 final drain");

      repeat (4) @(negedge clk);
      chk("R6 no stray completion", sb.size(), 0);
      finished = 1;
      report();
   end

endmodule